// File: doc/BRIEF.md
# Uncached Request Bridge with Pooled Transaction Entries

This block turns uncached and memory-mapped read and write requests into transactions on a simplified coherent-interconnect request/response interface. Requests arrive on a valid/ready request channel and are each held in one of a pool of independent entries. Each entry runs its own small state machine that issues the request, sends write data when the target is ready for it, collects the responses, and returns a single completion on a valid/ready response channel. The index of the holding entry doubles as the transaction identifier, so every downstream response is steered back to its entry by identifier alone.

Reads are sent with an ordering requirement, so the downstream returns a read receipt once it has accepted each read. To keep reads in order across the whole pool, no new read request leaves the bridge while any issued read is still missing its receipt; writes are not held back by this rule. A request refused downstream with a retry is parked until a protocol credit arrives; a small credit counter stands in for the credit-matching logic and hands stored credits to the lowest-numbered parked entry.

Each entry moves through the states FREE, ISSUE, WAIT, WDATA, CREDIT and RESP. Transitions: FREE to ISSUE on allocation; ISSUE to WAIT when its request is accepted; WAIT to CREDIT on a retry response; WAIT to WDATA when a write has its data-buffer response and has not yet sent data; WDATA to WAIT when data is accepted before completion, or WDATA to RESP when completion has already been seen; WAIT to RESP when a read has both receipt and data, or a write has sent data and seen completion; CREDIT to ISSUE when a credit is handed over; RESP to FREE when the completion is accepted.

Top module: `nc_req_bridge`

## Requirements
- R1: Out of reset `a_ready` is 1 and `txreq_valid`, `txdat_valid` and `d_valid` are 0.
- R2: A new request goes to the lowest-numbered free entry, and that entry's index is the transaction identifier on `txreq_txnid`, `txdat_txnid` and the incoming `rxrsp_txnid` / `rxdat_txnid`.
- R3: `a_ready` is 0 exactly when every entry is busy; a request offered while `a_ready` is 0 is not taken.
- R4: A read is issued with `txreq_write` = 0 (no-snoop read) and a write with `txreq_write` = 1 (no-snoop partial write), each carrying its request address.
- R5: While any issued read lacks its read receipt, `txreq_valid` is never asserted for a read; write requests still issue.
- R6: Write data appears on `txdat_valid` with the entry's identifier and data only after a data-buffer response (`rxrsp_opcode` 2) or combined completion and data-buffer response (opcode 3) for that identifier.
- R7: A read completes on the response channel with `d_with_data` = 1 and the data from `rxdat_data`, after both its receipt (opcode 0) and its data have arrived; a write completes with `d_with_data` = 0 after its data is sent and a completion (opcode 1 or 3) has arrived; `d_source` returns the request's source tag and `d_valid` holds until `d_ready`.
- R8: When several entries compete for the request, write-data or response output, the lowest index wins.
- R9: A retry response (opcode 4) parks its entry; the request is re-issued with the same identifier only after a `pcrd_grant` pulse, one cycle after the credit is stored.
- R10: An entry becomes free in the cycle after its completion is accepted, so a full pool raises `a_ready` again in that cycle.
- R11: A response only affects the entry whose identifier it carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| a_valid | input | 1 | Request offered |
| a_ready | output | 1 | Request accepted (a free entry exists) |
| a_write | input | 1 | 1 = write, 0 = read |
| a_addr | input | ADDR_W | Request address |
| a_data | input | DATA_W | Write data |
| a_source | input | SRC_W | Requester source tag |
| d_valid | output | 1 | Completion offered |
| d_ready | input | 1 | Completion accepted |
| d_with_data | output | 1 | 1 = read completion carrying data |
| d_source | output | SRC_W | Source tag of the completed request |
| d_data | output | DATA_W | Read data |
| txreq_valid | output | 1 | Downstream request offered |
| txreq_ready | input | 1 | Downstream request accepted |
| txreq_write | output | 1 | 1 = partial write, 0 = read |
| txreq_txnid | output | IDX_W | Transaction identifier (entry index) |
| txreq_addr | output | ADDR_W | Request address |
| txdat_valid | output | 1 | Write data offered |
| txdat_ready | input | 1 | Write data accepted |
| txdat_txnid | output | IDX_W | Identifier of the write data |
| txdat_data | output | DATA_W | Write data |
| rxrsp_valid | input | 1 | Response present |
| rxrsp_txnid | input | IDX_W | Response identifier |
| rxrsp_opcode | input | 3 | 0 receipt, 1 completion, 2 data-buffer, 3 completion+data-buffer, 4 retry |
| rxdat_valid | input | 1 | Read data present |
| rxdat_txnid | input | IDX_W | Read data identifier |
| rxdat_data | input | DATA_W | Read data |
| pcrd_grant | input | 1 | One protocol credit granted |

## Verification
A lone read and a lone write show each path end to end and separate the receipt and data-buffer conditions. Two reads followed by a write show the pool-wide read hold: the second read stays back while the write goes ahead, which tells a global gate from a per-entry one. A burst of eight writes against stalled outputs shows the full-pool refusal, lowest-index ordering on all three outputs and the one-cycle recycle of an entry. A retried read tells whether re-issue waits for the credit and keeps its identifier.

// File: rtl/nc_bridge_pkg.sv
package nc_bridge_pkg;

    typedef enum logic [2:0] {
        ST_FREE,
        ST_ISSUE,
        ST_WAIT,
        ST_WDATA,
        ST_CREDIT,
        ST_RESP
    } ent_state_e;

    localparam logic [2:0] RSP_RECEIPT   = 3'd0;
    localparam logic [2:0] RSP_COMP      = 3'd1;
    localparam logic [2:0] RSP_DBID      = 3'd2;
    localparam logic [2:0] RSP_COMP_DBID = 3'd3;
    localparam logic [2:0] RSP_RETRY     = 3'd4;

endpackage

// File: rtl/nc_bridge_prio.sv
module nc_bridge_prio #(
    parameter int N = 8
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    always_comb begin
        logic found;
        found = 1'b0;
        gnt   = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !found) begin
                gnt[i] = 1'b1;
                found  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/nc_bridge_credit_bank.sv
module nc_bridge_credit_bank #(
    parameter int N     = 8,
    parameter int CNT_W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         grant_in,
    input  logic [N-1:0] waiting,
    output logic [N-1:0] take
);
    logic [CNT_W-1:0] cnt;
    logic [N-1:0]     pick;

    nc_bridge_prio #(.N(N)) u_pick (
        .req (waiting),
        .gnt (pick)
    );

    assign take = (cnt != '0) ? pick : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (grant_in && !(|take)) begin
            if (cnt != '1) cnt <= cnt + CNT_W'(1);
        end else if (!grant_in && (|take)) begin
            cnt <= cnt - CNT_W'(1);
        end
    end
endmodule

// File: rtl/nc_bridge_entry.sv
module nc_bridge_entry
    import nc_bridge_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int SRC_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc,
    input  logic              alloc_write,
    input  logic [ADDR_W-1:0] alloc_addr,
    input  logic [DATA_W-1:0] alloc_data,
    input  logic [SRC_W-1:0]  alloc_src,
    input  logic              req_gnt,
    input  logic              dat_gnt,
    input  logic              d_gnt,
    input  logic              rsp_hit,
    input  logic [2:0]        rsp_op,
    input  logic              dat_hit,
    input  logic [DATA_W-1:0] dat_data,
    input  logic              credit_take,
    output logic              busy,
    output logic              want_req,
    output logic              want_dat,
    output logic              want_d,
    output logic              wait_rcpt,
    output logic              wait_credit,
    output logic              is_write,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [SRC_W-1:0]  src
);
    ent_state_e st, nxt;
    logic rcpt, gotd, dbid, comp, sent;
    logic rcpt_n, gotd_n, dbid_n, comp_n, sent_n;
    logic ev_rcpt, ev_comp, ev_dbid, ev_retry;

    assign ev_rcpt  = rsp_hit && (rsp_op == RSP_RECEIPT);
    assign ev_comp  = rsp_hit && ((rsp_op == RSP_COMP) || (rsp_op == RSP_COMP_DBID));
    assign ev_dbid  = rsp_hit && ((rsp_op == RSP_DBID) || (rsp_op == RSP_COMP_DBID));
    assign ev_retry = rsp_hit && (rsp_op == RSP_RETRY);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_FREE;
        else        st <= nxt;
    end

    // next state and progress flags
    always_comb begin
        nxt    = st;
        rcpt_n = rcpt;
        gotd_n = gotd;
        dbid_n = dbid;
        comp_n = comp;
        sent_n = sent;
        unique case (st)
            ST_FREE: begin
                if (alloc) begin
                    nxt    = ST_ISSUE;
                    rcpt_n = 1'b0;
                    gotd_n = 1'b0;
                    dbid_n = 1'b0;
                    comp_n = 1'b0;
                    sent_n = 1'b0;
                end
            end
            ST_ISSUE: begin
                if (req_gnt) nxt = ST_WAIT;
            end
            ST_WAIT: begin
                if (ev_retry) begin
                    nxt    = ST_CREDIT;
                    rcpt_n = 1'b0;
                    gotd_n = 1'b0;
                    dbid_n = 1'b0;
                    comp_n = 1'b0;
                    sent_n = 1'b0;
                end else if (!is_write) begin
                    rcpt_n = rcpt | ev_rcpt;
                    gotd_n = gotd | dat_hit;
                    if (rcpt_n && gotd_n) nxt = ST_RESP;
                end else begin
                    dbid_n = dbid | ev_dbid;
                    comp_n = comp | ev_comp;
                    if (dbid_n && !sent)     nxt = ST_WDATA;
                    else if (comp_n && sent) nxt = ST_RESP;
                end
            end
            ST_WDATA: begin
                comp_n = comp | ev_comp;
                if (dat_gnt) begin
                    sent_n = 1'b1;
                    nxt    = comp_n ? ST_RESP : ST_WAIT;
                end
            end
            ST_CREDIT: begin
                if (credit_take) nxt = ST_ISSUE;
            end
            ST_RESP: begin
                if (d_gnt) nxt = ST_FREE;
            end
            default: nxt = ST_FREE;
        endcase
    end

    // flags and request payload
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rcpt     <= 1'b0;
            gotd     <= 1'b0;
            dbid     <= 1'b0;
            comp     <= 1'b0;
            sent     <= 1'b0;
            is_write <= 1'b0;
            addr     <= '0;
            wdata    <= '0;
            rdata    <= '0;
            src      <= '0;
        end else begin
            rcpt <= rcpt_n;
            gotd <= gotd_n;
            dbid <= dbid_n;
            comp <= comp_n;
            sent <= sent_n;
            if (st == ST_FREE && alloc) begin
                is_write <= alloc_write;
                addr     <= alloc_addr;
                wdata    <= alloc_data;
                src      <= alloc_src;
            end
            if (st == ST_WAIT && !is_write && dat_hit && !ev_retry) rdata <= dat_data;
        end
    end

    // outputs
    always_comb begin
        busy        = (st != ST_FREE);
        want_req    = (st == ST_ISSUE);
        want_dat    = (st == ST_WDATA);
        want_d      = (st == ST_RESP);
        wait_rcpt   = (st == ST_WAIT) && !is_write && !rcpt;
        wait_credit = (st == ST_CREDIT);
    end
endmodule

// File: rtl/nc_req_bridge.sv
module nc_req_bridge
    import nc_bridge_pkg::*;
#(
    parameter  int N_ENT  = 8,
    parameter  int ADDR_W = 32,
    parameter  int DATA_W = 64,
    parameter  int SRC_W  = 4,
    parameter  int CRD_W  = 4,
    localparam int IDX_W  = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              a_valid,
    output logic              a_ready,
    input  logic              a_write,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_data,
    input  logic [SRC_W-1:0]  a_source,
    output logic              d_valid,
    input  logic              d_ready,
    output logic              d_with_data,
    output logic [SRC_W-1:0]  d_source,
    output logic [DATA_W-1:0] d_data,
    output logic              txreq_valid,
    input  logic              txreq_ready,
    output logic              txreq_write,
    output logic [IDX_W-1:0]  txreq_txnid,
    output logic [ADDR_W-1:0] txreq_addr,
    output logic              txdat_valid,
    input  logic              txdat_ready,
    output logic [IDX_W-1:0]  txdat_txnid,
    output logic [DATA_W-1:0] txdat_data,
    input  logic              rxrsp_valid,
    input  logic [IDX_W-1:0]  rxrsp_txnid,
    input  logic [2:0]        rxrsp_opcode,
    input  logic              rxdat_valid,
    input  logic [IDX_W-1:0]  rxdat_txnid,
    input  logic [DATA_W-1:0] rxdat_data,
    input  logic              pcrd_grant
);
    logic [N_ENT-1:0] busy_vec, want_req_vec, want_dat_vec, want_d_vec;
    logic [N_ENT-1:0] wait_rcpt_vec, wait_crd_vec, wr_vec;
    logic [N_ENT-1:0] alloc_gnt, req_vec, req_gnt, dat_gnt, d_gnt, take_vec;
    logic             read_block;

    logic [ADDR_W-1:0] ent_addr  [N_ENT];
    logic [DATA_W-1:0] ent_wdata [N_ENT];
    logic [DATA_W-1:0] ent_rdata [N_ENT];
    logic [SRC_W-1:0]  ent_src   [N_ENT];

    // pool-wide read ordering gate
    assign read_block = |wait_rcpt_vec;
    assign req_vec    = want_req_vec & (wr_vec | {N_ENT{~read_block}});

    nc_bridge_prio #(.N(N_ENT)) u_alloc_arb (.req(~busy_vec),   .gnt(alloc_gnt));
    nc_bridge_prio #(.N(N_ENT)) u_req_arb   (.req(req_vec),      .gnt(req_gnt));
    nc_bridge_prio #(.N(N_ENT)) u_dat_arb   (.req(want_dat_vec), .gnt(dat_gnt));
    nc_bridge_prio #(.N(N_ENT)) u_d_arb     (.req(want_d_vec),   .gnt(d_gnt));

    nc_bridge_credit_bank #(.N(N_ENT), .CNT_W(CRD_W)) u_credit (
        .clk      (clk),
        .rst_n    (rst_n),
        .grant_in (pcrd_grant),
        .waiting  (wait_crd_vec),
        .take     (take_vec)
    );

    assign a_ready     = |alloc_gnt;
    assign txreq_valid = |req_gnt;
    assign txdat_valid = |dat_gnt;
    assign d_valid     = |d_gnt;

    for (genvar i = 0; i < N_ENT; i++) begin : g_ent
        nc_bridge_entry #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W),
            .SRC_W  (SRC_W)
        ) u_ent (
            .clk         (clk),
            .rst_n       (rst_n),
            .alloc       (a_valid && alloc_gnt[i]),
            .alloc_write (a_write),
            .alloc_addr  (a_addr),
            .alloc_data  (a_data),
            .alloc_src   (a_source),
            .req_gnt     (req_gnt[i] && txreq_ready),
            .dat_gnt     (dat_gnt[i] && txdat_ready),
            .d_gnt       (d_gnt[i] && d_ready),
            .rsp_hit     (rxrsp_valid && (rxrsp_txnid == IDX_W'(i))),
            .rsp_op      (rxrsp_opcode),
            .dat_hit     (rxdat_valid && (rxdat_txnid == IDX_W'(i))),
            .dat_data    (rxdat_data),
            .credit_take (take_vec[i]),
            .busy        (busy_vec[i]),
            .want_req    (want_req_vec[i]),
            .want_dat    (want_dat_vec[i]),
            .want_d      (want_d_vec[i]),
            .wait_rcpt   (wait_rcpt_vec[i]),
            .wait_credit (wait_crd_vec[i]),
            .is_write    (wr_vec[i]),
            .addr        (ent_addr[i]),
            .wdata       (ent_wdata[i]),
            .rdata       (ent_rdata[i]),
            .src         (ent_src[i])
        );
    end

    // one-hot OR muxes onto the three outputs
    always_comb begin
        txreq_txnid = '0;
        txreq_write = 1'b0;
        txreq_addr  = '0;
        txdat_txnid = '0;
        txdat_data  = '0;
        d_with_data = 1'b0;
        d_source    = '0;
        d_data      = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (req_gnt[i]) begin
                txreq_txnid = txreq_txnid | IDX_W'(i);
                txreq_write = txreq_write | wr_vec[i];
                txreq_addr  = txreq_addr  | ent_addr[i];
            end
            if (dat_gnt[i]) begin
                txdat_txnid = txdat_txnid | IDX_W'(i);
                txdat_data  = txdat_data  | ent_wdata[i];
            end
            if (d_gnt[i]) begin
                d_with_data = d_with_data | ~wr_vec[i];
                d_source    = d_source    | ent_src[i];
                d_data      = d_data      | ent_rdata[i];
            end
        end
    end
endmodule

// File: rtl/nc_req_bridge_chk.sv
module nc_req_bridge_chk #(
    parameter int N_ENT = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             a_ready,
    input logic             txreq_valid,
    input logic             txreq_write,
    input logic             txdat_valid,
    input logic             txdat_ready,
    input logic             d_valid,
    input logic             d_ready,
    input logic             read_block,
    input logic [N_ENT-1:0] busy_vec,
    input logic [N_ENT-1:0] take_vec,
    input logic [N_ENT-1:0] wait_crd_vec
);
    assert_idle_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (a_ready && !txreq_valid && !txdat_valid && !d_valid));

    assert_full_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(busy_vec) == N_ENT) |-> !a_ready);

    assert_free_admits_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(busy_vec) < N_ENT) |-> a_ready);

    assert_read_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        read_block |-> !(txreq_valid && !txreq_write));

    assert_txdat_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (txdat_valid && !txdat_ready) |=> txdat_valid);

    assert_d_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (d_valid && !d_ready) |=> d_valid);

    assert_credit_to_waiter_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (take_vec != '0) |-> ($onehot0(take_vec) && ((take_vec & ~wait_crd_vec) == '0)));

    assert_slot_freed_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (d_valid && d_ready) |=> a_ready);
endmodule

bind nc_req_bridge nc_req_bridge_chk #(.N_ENT(N_ENT)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .a_ready      (a_ready),
    .txreq_valid  (txreq_valid),
    .txreq_write  (txreq_write),
    .txdat_valid  (txdat_valid),
    .txdat_ready  (txdat_ready),
    .d_valid      (d_valid),
    .d_ready      (d_ready),
    .read_block   (read_block),
    .busy_vec     (busy_vec),
    .take_vec     (take_vec),
    .wait_crd_vec (wait_crd_vec)
);

// File: tb/nc_req_bridge_test.sv
module nc_req_bridge_test;
    localparam int NE = 8;
    localparam int AW = 32;
    localparam int DW = 64;
    localparam int SW = 4;
    localparam int IW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic a_valid = 0, a_write = 0;
    logic [AW-1:0] a_addr = '0;
    logic [DW-1:0] a_data = '0;
    logic [SW-1:0] a_source = '0;
    logic a_ready, d_valid, d_with_data;
    logic d_ready = 1;
    logic [SW-1:0] d_source;
    logic [DW-1:0] d_data;
    logic txreq_valid, txreq_write;
    logic txreq_ready = 1;
    logic [IW-1:0] txreq_txnid;
    logic [AW-1:0] txreq_addr;
    logic txdat_valid;
    logic txdat_ready = 1;
    logic [IW-1:0] txdat_txnid;
    logic [DW-1:0] txdat_data;
    logic rxrsp_valid = 0;
    logic [IW-1:0] rxrsp_txnid = '0;
    logic [2:0] rxrsp_opcode = '0;
    logic rxdat_valid = 0;
    logic [IW-1:0] rxdat_txnid = '0;
    logic [DW-1:0] rxdat_data = '0;
    logic pcrd_grant = 0;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    nc_req_bridge #(.N_ENT(NE), .ADDR_W(AW), .DATA_W(DW), .SRC_W(SW), .CRD_W(4)) uut (
        .clk(clk), .rst_n(rst_n),
        .a_valid(a_valid), .a_ready(a_ready), .a_write(a_write), .a_addr(a_addr),
        .a_data(a_data), .a_source(a_source),
        .d_valid(d_valid), .d_ready(d_ready), .d_with_data(d_with_data),
        .d_source(d_source), .d_data(d_data),
        .txreq_valid(txreq_valid), .txreq_ready(txreq_ready), .txreq_write(txreq_write),
        .txreq_txnid(txreq_txnid), .txreq_addr(txreq_addr),
        .txdat_valid(txdat_valid), .txdat_ready(txdat_ready), .txdat_txnid(txdat_txnid),
        .txdat_data(txdat_data),
        .rxrsp_valid(rxrsp_valid), .rxrsp_txnid(rxrsp_txnid), .rxrsp_opcode(rxrsp_opcode),
        .rxdat_valid(rxdat_valid), .rxdat_txnid(rxdat_txnid), .rxdat_data(rxdat_data),
        .pcrd_grant(pcrd_grant)
    );

    task automatic cmp(string tag, string what, logic [63:0] act, logic [63:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    // entry phases: 0 idle, 1 to send, 2 awaiting replies, 3 data to send, 4 parked, 5 reply due
    int            m_st [NE];
    bit            m_wr [NE], m_rc [NE], m_gd [NE], m_db [NE], m_cp [NE], m_sn [NE];
    logic [AW-1:0] m_addr [NE];
    logic [DW-1:0] m_wd [NE], m_rd [NE];
    logic [SW-1:0] m_src [NE];
    int            credits;

    function automatic int lowest(int phase, bit read_gate);
        for (int i = 0; i < NE; i++)
            if (m_st[i] == phase && (!read_gate || m_wr[i] || !read_pending())) return i;
        return -1;
    endfunction

    function automatic bit read_pending();
        for (int i = 0; i < NE; i++)
            if (m_st[i] == 2 && !m_wr[i] && !m_rc[i]) return 1'b1;
        return 1'b0;
    endfunction

    always @(negedge clk) begin : model
        int ai, ri, di, qi, ci;
        bit hit;
        if (!rst_n) begin
            for (int i = 0; i < NE; i++) begin
                m_st[i] = 0; m_rc[i] = 0; m_gd[i] = 0; m_db[i] = 0; m_cp[i] = 0; m_sn[i] = 0;
                m_wr[i] = 0; m_rd[i] = '0;
            end
            credits = 0;
        end else begin
            ai = lowest(0, 1'b0);
            ri = lowest(1, 1'b1);
            di = lowest(3, 1'b0);
            qi = lowest(5, 1'b0);
            ci = (credits > 0) ? lowest(4, 1'b0) : -1;
            cmp("R3", "a_ready", 64'(a_ready), 64'(ai >= 0));
            cmp("R5", "txreq_valid", 64'(txreq_valid), 64'(ri >= 0));
            if (ri >= 0) begin
                cmp("R2", "txreq_txnid", 64'(txreq_txnid), 64'(ri));
                cmp("R4", "txreq_write", 64'(txreq_write), 64'(m_wr[ri]));
                cmp("R4", "txreq_addr", 64'(txreq_addr), 64'(m_addr[ri]));
            end
            cmp("R6", "txdat_valid", 64'(txdat_valid), 64'(di >= 0));
            if (di >= 0) begin
                cmp("R6", "txdat_txnid", 64'(txdat_txnid), 64'(di));
                cmp("R6", "txdat_data", txdat_data, m_wd[di]);
            end
            cmp("R7", "d_valid", 64'(d_valid), 64'(qi >= 0));
            if (qi >= 0) begin
                cmp("R7", "d_source", 64'(d_source), 64'(m_src[qi]));
                cmp("R7", "d_with_data", 64'(d_with_data), 64'(!m_wr[qi]));
                if (!m_wr[qi]) cmp("R7", "d_data", d_data, m_rd[qi]);
            end
            for (int i = 0; i < NE; i++) begin
                hit = rxrsp_valid && (int'(rxrsp_txnid) == i);
                case (m_st[i])
                    0: if (a_valid && ai == i) begin
                        m_st[i] = 1; m_wr[i] = a_write; m_addr[i] = a_addr; m_wd[i] = a_data;
                        m_src[i] = a_source;
                        m_rc[i] = 0; m_gd[i] = 0; m_db[i] = 0; m_cp[i] = 0; m_sn[i] = 0;
                    end
                    1: if (ri == i && txreq_ready) m_st[i] = 2;
                    2: begin
                        if (hit && rxrsp_opcode == 3'd4) begin
                            m_st[i] = 4;
                            m_rc[i] = 0; m_gd[i] = 0; m_db[i] = 0; m_cp[i] = 0; m_sn[i] = 0;
                        end else if (!m_wr[i]) begin
                            if (hit && rxrsp_opcode == 3'd0) m_rc[i] = 1;
                            if (rxdat_valid && int'(rxdat_txnid) == i) begin
                                m_gd[i] = 1; m_rd[i] = rxdat_data;
                            end
                            if (m_rc[i] && m_gd[i]) m_st[i] = 5;
                        end else begin
                            if (hit && (rxrsp_opcode == 3'd2 || rxrsp_opcode == 3'd3)) m_db[i] = 1;
                            if (hit && (rxrsp_opcode == 3'd1 || rxrsp_opcode == 3'd3)) m_cp[i] = 1;
                            if (m_db[i] && !m_sn[i]) m_st[i] = 3;
                            else if (m_cp[i] && m_sn[i]) m_st[i] = 5;
                        end
                    end
                    3: begin
                        if (hit && (rxrsp_opcode == 3'd1 || rxrsp_opcode == 3'd3)) m_cp[i] = 1;
                        if (di == i && txdat_ready) begin
                            m_sn[i] = 1;
                            m_st[i] = m_cp[i] ? 5 : 2;
                        end
                    end
                    4: if (ci == i) m_st[i] = 1;
                    5: if (qi == i && d_ready) m_st[i] = 0;
                    default: ;
                endcase
            end
            if (pcrd_grant && ci < 0) begin
                if (credits < 15) credits++;
            end else if (!pcrd_grant && ci >= 0) begin
                credits--;
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic send_a(bit w, logic [AW-1:0] ad, logic [DW-1:0] dt, logic [SW-1:0] s);
        @(posedge clk); #1;
        a_valid = 1; a_write = w; a_addr = ad; a_data = dt; a_source = s;
        @(posedge clk); #1;
        a_valid = 0;
    endtask

    task automatic send_rsp(int id, logic [2:0] op);
        @(posedge clk); #1;
        rxrsp_valid = 1; rxrsp_txnid = IW'(id); rxrsp_opcode = op;
        @(posedge clk); #1;
        rxrsp_valid = 0;
    endtask

    task automatic send_dat(int id, logic [DW-1:0] dt);
        @(posedge clk); #1;
        rxdat_valid = 1; rxdat_txnid = IW'(id); rxdat_data = dt;
        @(posedge clk); #1;
        rxdat_valid = 0;
    endtask

    task automatic send_credit();
        @(posedge clk); #1;
        pcrd_grant = 1;
        @(posedge clk); #1;
        pcrd_grant = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic look();
        @(negedge clk);
        #0.1;
    endtask

    // ---------------- scenarios ----------------
    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // reset state
        look();
        cmp("R1", "a_ready after reset", 64'(a_ready), 64'd1);
        cmp("R1", "txreq_valid after reset", 64'(txreq_valid), 64'd0);
        cmp("R1", "txdat_valid after reset", 64'(txdat_valid), 64'd0);
        cmp("R1", "d_valid after reset", 64'(d_valid), 64'd0);

        // lone read
        send_a(0, 32'h0000_1000, '0, 4'd3);
        look();
        cmp("R2", "first txnid", 64'(txreq_txnid), 64'd0);
        cmp("R4", "read opcode", 64'(txreq_write), 64'd0);
        send_rsp(0, 3'd0);
        send_dat(0, 64'hA5A5_0000_1111_2222);
        look();
        cmp("R7", "read completion valid", 64'(d_valid), 64'd1);
        cmp("R7", "read completion data", d_data, 64'hA5A5_0000_1111_2222);
        cmp("R7", "read completion source", 64'(d_source), 64'd3);
        idle(3);

        // two reads then a write: pool-wide read hold
        send_a(0, 32'h0000_2000, '0, 4'd1);
        send_a(0, 32'h0000_2040, '0, 4'd2);
        look();
        cmp("R5", "second read held", 64'(txreq_valid), 64'd0);
        send_a(1, 32'h0000_3000, 64'h33, 4'd4);
        look();
        cmp("R5", "write passes read hold", 64'(txreq_valid), 64'd1);
        cmp("R4", "write opcode", 64'(txreq_write), 64'd1);
        cmp("R2", "write txnid", 64'(txreq_txnid), 64'd2);
        cmp("R6", "no data before buffer response", 64'(txdat_valid), 64'd0);
        send_rsp(2, 3'd2);
        look();
        cmp("R6", "write data offered", 64'(txdat_valid), 64'd1);
        cmp("R11", "data for txnid 2 only", 64'(txdat_txnid), 64'd2);
        cmp("R11", "read still held", 64'(txreq_valid), 64'd0);
        send_rsp(0, 3'd0);
        look();
        cmp("R5", "held read released", 64'(txreq_valid), 64'd1);
        cmp("R5", "released read txnid", 64'(txreq_txnid), 64'd1);
        send_rsp(2, 3'd1);
        send_dat(0, 64'h0123_4567_89AB_CDEF);
        send_rsp(1, 3'd0);
        send_dat(1, 64'hFEDC_BA98_7654_3210);
        idle(6);

        // fill the pool with stalled outputs
        txreq_ready = 0;
        d_ready = 0;
        for (int k = 0; k < NE; k++) send_a(1, AW'(32'h100 * k), DW'(k + 16), SW'(k));
        look();
        cmp("R3", "full pool refuses", 64'(a_ready), 64'd0);
        cmp("R8", "lowest request first", 64'(txreq_txnid), 64'd0);
        send_a(0, 32'hDEAD_0000, '0, 4'd15);
        @(posedge clk); #1 txreq_ready = 1;
        look();
        cmp("R8", "request order 0", 64'(txreq_txnid), 64'd0);
        look();
        cmp("R8", "request order 1", 64'(txreq_txnid), 64'd1);
        idle(10);
        for (int k = 0; k < NE; k++) send_rsp(k, 3'd3);
        idle(3);
        look();
        cmp("R8", "lowest completion first", 64'(d_source), 64'd0);
        @(posedge clk); #1 d_ready = 1;
        @(posedge clk); #1 d_ready = 0;
        look();
        cmp("R10", "slot free after completion", 64'(a_ready), 64'd1);
        cmp("R8", "next completion", 64'(d_source), 64'd1);
        @(posedge clk); #1 d_ready = 1;
        idle(12);

        // retried read
        send_a(0, 32'h0000_4000, '0, 4'd6);
        idle(1);
        send_rsp(0, 3'd4);
        look();
        cmp("R9", "parked without credit", 64'(txreq_valid), 64'd0);
        send_dat(6, 64'h1);
        idle(3);
        look();
        cmp("R9", "still parked", 64'(txreq_valid), 64'd0);
        send_credit();
        look();
        cmp("R9", "credit stored, not yet used", 64'(txreq_valid), 64'd0);
        look();
        cmp("R9", "re-issued after credit", 64'(txreq_valid), 64'd1);
        cmp("R9", "same txnid on re-issue", 64'(txreq_txnid), 64'd0);
        idle(1);
        send_rsp(0, 3'd0);
        send_dat(0, 64'h5555_AAAA_5555_AAAA);
        idle(5);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end
endmodule